// File: doc/BRIEF.md
# Fixed-Point Dense Layer with Class Selection

This block evaluates one fully connected layer of a small recurrent classifier. For every output element `j` it forms the dot product of the stored activation vector with column `j` of the stored weight matrix, adds that column's bias once, and requantizes the result to the activation format. The dot product is split across four multiply-accumulate lanes, each covering a contiguous quarter of the input vector. The four partial sums are reduced together with the bias in a single step.

Activations, weights and biases live in register arrays that are written through a simple load port. A start pulse launches one pass in either hidden mode (64 outputs) or output mode (6 outputs). Results stream out one element at a time with their index. In output mode the block also tracks the running maximum and reports the winning class when the last element leaves. A one-cycle done pulse marks the end of each pass.

Top module: `dense_argmax`

## Requirements
- R1: In hidden mode (`mode_i`=0 at start) the block emits 64 results, index 0 to 63 in ascending order. Each one is the requantized value of bias[j]·2^8 + Σk x[k]·W[k][j] over all 64 inputs, with the bias counted exactly once.
- R2: In output mode (`mode_i`=1 at start) the block emits 6 results, index 0 to 5, using weight columns 0 to 5 and biases 0 to 5.
- R3: Activations and results are 14-bit two's complement with 8 fraction bits; weights and biases are 14-bit two's complement with 12 fraction bits. Products are kept at full width and summed exactly. The sum is rounded by adding 2^11 and shifting right arithmetically by 12, so an exact half rounds toward positive infinity.
- R4: A rounded sum above 8191 yields 8191, and a rounded sum below -8192 yields -8192. There is no wraparound.
- R5: When `done_o` is high in output mode, `class_o` holds the index of the largest of the 6 results, and on a tie the lowest index wins. In hidden mode `class_o` is 0 with `done_o`.
- R6: `done_o` is high for exactly one cycle per pass, in the same cycle as the last result's `res_valid_o`, and `busy_o` is already low in that cycle.
- R7: A `start_i` pulse while `busy_o` is high has no effect. The running pass keeps its mode, its results and its single done pulse.
- R8: The load port writes on `ld_we_i` according to `ld_sel_i`. The value 0 writes activation `ld_addr_i[5:0]`. The value 1 writes weight W[k][j] with k=`ld_addr_i[11:6]` and j=`ld_addr_i[5:0]`. The value 2 writes bias `ld_addr_i[5:0]`. The value 3 writes nothing.
- R9: After reset `busy_o`, `res_valid_o`, `done_o` and `class_o` are all 0.
- R10: The first result appears 17 clock edges after the edge that samples `start_i`, and following results follow every 17 edges. This is 16 accumulate cycles and one reduce cycle per element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_we_i | input | 1 | Load write enable |
| ld_sel_i | input | 2 | Load target: 0 activation, 1 weight, 2 bias |
| ld_addr_i | input | 12 | Load address (weight: {k, j}) |
| ld_data_i | input | 14 | Load data, two's complement |
| mode_i | input | 1 | 0 hidden (64 outputs), 1 output (6 outputs); sampled with start |
| start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Pass in progress |
| res_valid_o | output | 1 | Result element valid |
| res_idx_o | output | 6 | Index of the result element |
| res_data_o | output | 14 | Result element, 8 fraction bits |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| class_o | output | 3 | Winning class index, valid with done |

## Verification
The bench aims at the requantizer's edges. It drives exact half-LSB sums, one LSB either side of the half, and sums far beyond both rails. A design that truncated instead of rounding, rounded halves away from zero, or let the result wrap would produce a wrong value or a value with the wrong sign. Ties among the six class outputs test the selection: a design using a non-strict compare would report the last maximum instead of the first. A second start issued mid-pass checks that the design does not restart, switch mode, emit extra elements or pulse done twice. Fixed latency checks catch a lane that drops or repeats an input slice.

// File: rtl/dl_pkg.sv
package dl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MAC,
    ST_RED
  } dl_state_e;

  localparam logic [1:0] LD_ACT  = 2'd0;
  localparam logic [1:0] LD_WGT  = 2'd1;
  localparam logic [1:0] LD_BIAS = 2'd2;
endpackage

// File: rtl/dl_mac_lane.sv
module dl_mac_lane #(
  parameter int unsigned ACT_W = 14,
  parameter int unsigned WGT_W = 14,
  parameter int unsigned ACC_W = 35
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic signed [ACT_W-1:0] x_i,
  input  logic signed [WGT_W-1:0] w_i,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int unsigned PW = ACT_W + WGT_W;

  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] prod_ext;

  assign prod     = x_i * w_i;
  assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (en_i)  acc_o <= acc_o + prod_ext;
  end
endmodule

// File: rtl/dl_requant.sv
module dl_requant #(
  parameter int unsigned ACC_W = 35,
  parameter int unsigned SHIFT = 12,
  parameter int unsigned OUT_W = 14
) (
  input  logic signed [ACC_W-1:0] sum_i,
  output logic signed [OUT_W-1:0] q_o
);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (SHIFT-1);

  logic signed [ACC_W-1:0] rnd, shr;

  always_comb begin
    rnd = sum_i + HALF;
    shr = rnd >>> SHIFT;
    if (shr > MAXV)      q_o = MAXV[OUT_W-1:0];
    else if (shr < MINV) q_o = MINV[OUT_W-1:0];
    else                 q_o = shr[OUT_W-1:0];
  end
endmodule

// File: rtl/dl_argmax.sv
module dl_argmax #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned VAL_W = 14
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_i,
  input  logic                    first_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic signed [VAL_W-1:0] val_i,
  output logic [IDX_W-1:0]        win_idx_o
);
  logic signed [VAL_W-1:0] best_val_q;
  logic [IDX_W-1:0]        best_idx_q;
  logic                    take;

  // strict compare keeps the earliest maximum
  assign take      = first_i || (val_i > best_val_q);
  assign win_idx_o = take ? idx_i : best_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_val_q <= '0;
      best_idx_q <= '0;
    end else if (upd_i && take) begin
      best_val_q <= val_i;
      best_idx_q <= idx_i;
    end
  end
endmodule

// File: rtl/dense_argmax.sv
module dense_argmax
  import dl_pkg::*;
#(
  parameter int unsigned IN_DIM   = 64,
  parameter int unsigned HID_DIM  = 64,
  parameter int unsigned CLS_DIM  = 6,
  parameter int unsigned LANES    = 4,
  parameter int unsigned ACT_W    = 14,
  parameter int unsigned ACT_FRAC = 8,
  parameter int unsigned WGT_W    = 14,
  parameter int unsigned WGT_FRAC = 12,
  localparam int unsigned K_W    = $clog2(IN_DIM),
  localparam int unsigned J_W    = $clog2(HID_DIM),
  localparam int unsigned CLS_W  = $clog2(CLS_DIM),
  localparam int unsigned ADDR_W = K_W + J_W,
  localparam int unsigned DATA_W = (ACT_W > WGT_W) ? ACT_W : WGT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_we_i,
  input  logic [1:0]        ld_sel_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              mode_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              res_valid_o,
  output logic [J_W-1:0]    res_idx_o,
  output logic [ACT_W-1:0]  res_data_o,
  output logic              done_o,
  output logic [CLS_W-1:0]  class_o
);
  localparam int unsigned SEG   = IN_DIM / LANES;
  localparam int unsigned C_W   = $clog2(SEG);
  localparam int unsigned ACC_W = ACT_W + WGT_W + K_W + 1;

  logic signed [ACT_W-1:0] act_q  [IN_DIM];
  logic signed [WGT_W-1:0] wgt_q  [IN_DIM][HID_DIM];
  logic signed [WGT_W-1:0] bias_q [HID_DIM];

  dl_state_e       state_q;
  logic [C_W-1:0]  cnt_q;
  logic [J_W-1:0]  j_q;
  logic            mode_q;
  logic            last_j;
  logic            lane_clr, lane_en, red;

  logic signed [ACC_W-1:0] lane_acc [LANES];
  logic signed [ACC_W-1:0] bias_ext, sum;
  logic signed [ACT_W-1:0] q_val;
  logic [J_W-1:0]          win_idx;

  // load port
  always_ff @(posedge clk_i) begin
    if (ld_we_i) begin
      case (ld_sel_i)
        LD_ACT:  act_q[ld_addr_i[K_W-1:0]] <= ld_data_i[ACT_W-1:0];
        LD_WGT:  wgt_q[ld_addr_i[ADDR_W-1:J_W]][ld_addr_i[J_W-1:0]] <= ld_data_i[WGT_W-1:0];
        LD_BIAS: bias_q[ld_addr_i[J_W-1:0]] <= ld_data_i[WGT_W-1:0];
        default: ;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign red      = (state_q == ST_RED);
  assign lane_en  = (state_q == ST_MAC);
  assign lane_clr = ((state_q == ST_IDLE) && start_i) || red;
  assign last_j   = mode_q ? (j_q == J_W'(CLS_DIM - 1)) : (j_q == J_W'(HID_DIM - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      j_q     <= '0;
      mode_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_MAC;
          cnt_q   <= '0;
          j_q     <= '0;
          mode_q  <= mode_i;
        end
        ST_MAC: begin
          cnt_q <= cnt_q + C_W'(1);
          if (cnt_q == C_W'(SEG - 1)) state_q <= ST_RED;
        end
        ST_RED: begin
          cnt_q <= '0;
          if (last_j) state_q <= ST_IDLE;
          else begin
            state_q <= ST_MAC;
            j_q     <= j_q + J_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // each lane walks its own contiguous slice of the input vector
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned BASE = g * SEG;
    logic [K_W-1:0] k_idx;
    assign k_idx = K_W'(BASE) + K_W'(cnt_q);

    dl_mac_lane #(
      .ACT_W(ACT_W),
      .WGT_W(WGT_W),
      .ACC_W(ACC_W)
    ) i_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (lane_clr),
      .en_i  (lane_en),
      .x_i   (act_q[k_idx]),
      .w_i   (wgt_q[k_idx][j_q]),
      .acc_o (lane_acc[g])
    );
  end

  // bias aligned to product scale (ACT_FRAC + WGT_FRAC fraction bits)
  assign bias_ext = {{(ACC_W-WGT_W){bias_q[j_q][WGT_W-1]}}, bias_q[j_q]} <<< ACT_FRAC;

  always_comb begin
    sum = bias_ext;
    for (int l = 0; l < LANES; l++) sum = sum + lane_acc[l];
  end

  dl_requant #(
    .ACC_W(ACC_W),
    .SHIFT(WGT_FRAC),
    .OUT_W(ACT_W)
  ) i_requant (
    .sum_i(sum),
    .q_o  (q_val)
  );

  dl_argmax #(
    .IDX_W(J_W),
    .VAL_W(ACT_W)
  ) i_argmax (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (red),
    .first_i  (j_q == '0),
    .idx_i    (j_q),
    .val_i    (q_val),
    .win_idx_o(win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_idx_o   <= '0;
      res_data_o  <= '0;
      done_o      <= 1'b0;
      class_o     <= '0;
    end else begin
      res_valid_o <= red;
      done_o      <= red && last_j;
      if (red) begin
        res_idx_o  <= j_q;
        res_data_o <= q_val;
      end
      if (red && last_j) class_o <= mode_q ? win_idx[CLS_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/dense_argmax_chk.sv
module dense_argmax_chk #(
  parameter int unsigned CLS_DIM = 6,
  parameter int unsigned CLS_W   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             res_valid_o,
  input logic             done_o,
  input logic [CLS_W-1:0] class_o
);
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_with_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> res_valid_o);

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r7_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r10_valid_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  a_r5_class_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (class_o < CLS_W'(CLS_DIM)));
endmodule

bind dense_argmax dense_argmax_chk #(
  .CLS_DIM(CLS_DIM),
  .CLS_W  (CLS_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .res_valid_o(res_valid_o),
  .done_o     (done_o),
  .class_o    (class_o)
);

// File: tb/test_dense_argmax.sv
`timescale 1ns/1ps
module test_dense_argmax;
  localparam int IN  = 64;
  localparam int HID = 64;
  localparam int CLS = 6;
  localparam int AF  = 8;
  localparam int WF  = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_we_i = 1'b0;
  logic [1:0]  ld_sel_i = '0;
  logic [11:0] ld_addr_i = '0;
  logic [13:0] ld_data_i = '0;
  logic        mode_i = 1'b0;
  logic        start_i = 1'b0;
  logic        busy_o, res_valid_o, done_o;
  logic [5:0]  res_idx_o;
  logic [13:0] res_data_o;
  logic [2:0]  class_o;

  dense_argmax i_dense_argmax (.*);

  always #2.5 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int x_m [IN];
  int w_m [IN][HID];
  int b_m [HID];

  typedef struct { int idx; int val; } exp_t;
  exp_t  exp_q[$];
  int    exp_cls;
  int    n_res, n_done, start_cyc, last_cyc;
  bit    first_valid;
  string cur_req = "R1";
  int    n_checks = 0, n_err = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_out(int j);
    longint s;
    s = longint'(b_m[j]) <<< AF;
    for (int k = 0; k < IN; k++) s += longint'(x_m[k]) * longint'(w_m[k][j]);
    s = (s + (longint'(1) <<< (WF - 1))) >>> WF;
    if (s > 8191)  s = 8191;
    if (s < -8192) s = -8192;
    return int'(s);
  endfunction

  task automatic ld(input logic [1:0] sel, input int addr, input int data);
    ld_we_i   = 1'b1;
    ld_sel_i  = sel;
    ld_addr_i = addr[11:0];
    ld_data_i = data[13:0];
    @(negedge clk_i);
  endtask

  task automatic load_all();
    for (int k = 0; k < IN; k++) ld(2'd0, k, x_m[k]);
    for (int j = 0; j < HID; j++) ld(2'd2, j, b_m[j]);
    for (int k = 0; k < IN; k++)
      for (int j = 0; j < HID; j++) ld(2'd1, (k << 6) | j, w_m[k][j]);
    // select 3 must write nothing (R8): junk to activation 0's address
    ld(2'd3, 0, 8191);
    ld_we_i = 1'b0;
  endtask

  task automatic run(input bit mode, input string req, input bit restart);
    int n_out, best;
    n_out = mode ? CLS : HID;
    exp_q.delete();
    best = 0;
    for (int j = 0; j < n_out; j++) begin
      exp_t e;
      e.idx = j;
      e.val = model_out(j);
      exp_q.push_back(e);
      if (j == 0 || e.val > exp_q[best].val) best = j;
    end
    exp_cls     = mode ? best : 0;
    n_res       = 0;
    n_done      = 0;
    first_valid = 1'b1;
    cur_req     = req;
    mode_i  = mode;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i   = 1'b0;
    start_cyc = cyc;
    if (restart) begin
      repeat (5) @(negedge clk_i);
      mode_i  = ~mode;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (n_done == 0) @(negedge clk_i);
    repeat (40) @(negedge clk_i);
    check(n_res == n_out, restart ? "R7" : "R6", "result count", n_res, n_out);
    check(n_done == 1, restart ? "R7" : "R6", "done count", n_done, 1);
    check(exp_q.size() == 0, req, "missing results", exp_q.size(), 0);
    check(busy_o == 1'b0, "R6", "busy after pass", busy_o, 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && done_o && !res_valid_o)
      check(1'b0, "R6", "done without last result", 0, 1);
    if (rst_ni && res_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected result idx", res_idx_o, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(res_idx_o) == e.idx, cur_req, "result index", res_idx_o, e.idx);
        check(int'($signed(res_data_o)) == e.val, cur_req, "result value",
              int'($signed(res_data_o)), e.val);
      end
      if (first_valid)
        check(cyc - start_cyc == 17, "R10", "first latency", cyc - start_cyc, 17);
      else
        check(cyc - last_cyc == 17, "R10", "result spacing", cyc - last_cyc, 17);
      last_cyc    = cyc;
      first_valid = 1'b0;
      n_res++;
      if (done_o) begin
        n_done++;
        check(int'(class_o) == exp_cls, "R5", "class", class_o, exp_cls);
      end
    end
  end

  initial begin
    #1000000;
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9: reset state
    check(busy_o == 0, "R9", "busy in reset", busy_o, 0);
    check(res_valid_o == 0, "R9", "valid in reset", res_valid_o, 0);
    check(done_o == 0, "R9", "done in reset", done_o, 0);
    check(class_o == 0, "R9", "class in reset", class_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 0, "R9", "busy after reset", busy_o, 0);

    // R1/R8: hidden mode, random data
    for (int k = 0; k < IN; k++) begin
      x_m[k] = int'($urandom_range(4095)) - 2048;
      for (int j = 0; j < HID; j++) w_m[k][j] = int'($urandom_range(1023)) - 512;
    end
    for (int j = 0; j < HID; j++) b_m[j] = int'($urandom_range(16383)) - 8192;
    load_all();
    run(1'b0, "R1", 1'b0);

    // R2/R5: output mode on same data
    run(1'b1, "R2", 1'b0);

    // R7: second start mid-pass, opposite mode
    run(1'b1, "R7", 1'b1);

    // R4: saturation on both rails
    for (int k = 0; k < IN; k++) begin
      x_m[k] = 8191;
      for (int j = 0; j < HID; j++) w_m[k][j] = (j % 2 == 1) ? -8192 : 8191;
    end
    for (int j = 0; j < HID; j++) b_m[j] = 0;
    load_all();
    run(1'b0, "R4", 1'b0);

    // R3: rounding of exact halves and neighbours, bias once
    for (int k = 0; k < IN; k++) begin
      x_m[k] = (k == 0) ? 1 : 0;
      for (int j = 0; j < HID; j++) w_m[k][j] = 0;
    end
    for (int j = 0; j < HID; j++) b_m[j] = 0;
    w_m[0][0] = 2048;  w_m[0][1] = 2047; w_m[0][2] = -2048;
    w_m[0][3] = -2049; w_m[0][4] = 6144; b_m[5] = 4096;
    load_all();
    check(model_out(0) == 1 && model_out(1) == 0 && model_out(2) == 0 &&
          model_out(3) == -1 && model_out(4) == 2 && model_out(5) == 256,
          "R3", "rounding vector", model_out(0), 1);
    run(1'b1, "R3", 1'b0);

    // R5: tie, lowest index wins
    for (int k = 0; k < IN; k++) begin
      x_m[k] = 0;
      for (int j = 0; j < HID; j++) w_m[k][j] = 0;
    end
    for (int j = 0; j < HID; j++) b_m[j] = 0;
    b_m[0] = 20; b_m[1] = 400; b_m[2] = 400; b_m[3] = -4; b_m[4] = 400; b_m[5] = 8;
    load_all();
    run(1'b1, "R5", 1'b0);
    check(exp_cls == 1, "R5", "tie reference", exp_cls, 1);

    // R5: all equal -> class 0
    for (int j = 0; j < HID; j++) begin
      b_m[j] = 160;
      ld(2'd2, j, 160);
    end
    ld_we_i = 1'b0;
    run(1'b1, "R5", 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule